// File: doc/BRIEF.md
# Modem Control and Status Register Pair with Loopback

This block holds the modem control register of a 16550-style serial port and produces the matching modem status register value, including its four change-detect bits. Software writes the control value through a simple write strobe; the block keeps the five defined control bits and computes the four status lines from them. With the loopback bit set, each control output is routed back onto one status input. With loopback clear, no physical modem pins are involved: the carrier-detect and data-set-ready lines read high and clear-to-send and ring read low.

Each control write compares the newly computed status lines with the ones held before the write and sets the matching change-detect bits. The ring line reports only its falling edge. Change bits stay set until the register bus reads the status register. The read strobe returns the current value and clears the four change bits on the following edge. A registered summary output tells the interrupt logic that at least one change bit is pending.

Top module: `mdm_ctrl_status`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0xA0 (carrier-detect bit 7 and data-set-ready bit 5 set, all change bits clear) and `delta_pend` is 0.
- R2: A control write keeps only bits 4..0 of the written byte; bits 7..5 of `mcr_q` always read 0. Control bit layout: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loopback.
- R3: With loopback set, status bit 4 (CTS) follows RTS, bit 5 (DSR) follows DTR, bit 6 (RI) follows OUT1 and bit 7 (DCD) follows OUT2.
- R4: With loopback clear, status bits 7..4 read 1,0,1,0 (DCD and DSR high, RI and CTS low) whatever the other control bits hold.
- R5: On a control write, bit 0 (CTS change), bit 1 (DSR change) and bit 3 (DCD change) are set when the matching status line differs from its value before the write.
- R6: Bit 2 (ring trailing edge) is set on a control write only when RI goes from 1 to 0; a 0 to 1 change of RI sets nothing.
- R7: Change bits already set stay set across control writes, and status bits 7..4 take the newly computed lines on every write; with neither strobe active the status register holds.
- R8: `msr_q` shows the current value while `msr_rd` is high; on the edge that ends the read the four change bits clear and bits 7..4 are left as they were.
- R9: `delta_pend` is 1 exactly when at least one of `msr_q[3:0]` is set, in the same cycle.
- R10: When a read and a control write fall in the same cycle, the change bits held before that cycle are cleared and the changes detected by the write are kept.
- R11: A control write that leaves all four status lines unchanged sets no change bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mcr_wr | input | 1 | Control register write strobe |
| mcr_wdata | input | 8 | Control register write data |
| msr_rd | input | 1 | Status register read strobe (clears change bits) |
| mcr_q | output | 8 | Control register value |
| msr_q | output | 8 | Status register value |
| delta_pend | output | 1 | At least one change bit is set |

## Verification
The bench builds the block with its default register width of 8 and the default idle line pattern of DCD and DSR high, the only settings for which the bit layouts above apply. With those values every one of the sixteen loopback line combinations is reachable from the control byte, so the bench can drive single-line patterns to isolate each mapping, walk RI in both directions to separate the trailing-edge rule from plain toggle detection, and move into and out of loopback to see the idle pattern take over. Same-cycle read and write and a reset in the middle of a run are driven as well.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int MCR_DTR  = 0;
  localparam int MCR_RTS  = 1;
  localparam int MCR_OUT1 = 2;
  localparam int MCR_OUT2 = 3;
  localparam int MCR_LOOP = 4;
  localparam int MCR_KEEP = 5;

  // Packed so that the order matches status bits 7..4.
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  // Packed so that the order matches status bits 3..0.
  typedef struct packed {
    logic ddcd;
    logic teri;
    logic ddsr;
    logic dcts;
  } mdm_delta_t;
endpackage

// File: rtl/mdm_ctrl_reg.sv
module mdm_ctrl_reg #(
  parameter int REG_W  = 8,
  parameter int KEEP_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mcr_masked,
  output logic [REG_W-1:0] mcr_q
);
  localparam logic [REG_W-1:0] KEEP_MASK = REG_W'((1 << KEEP_W) - 1);

  assign mcr_masked = wr_data & KEEP_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      mcr_q <= '0;
    end else if (wr_en) begin
      mcr_q <= mcr_masked;
    end
  end
endmodule

// File: rtl/mdm_line_map.sv
module mdm_line_map
  import mdm_pkg::*;
#(
  parameter int         REG_W      = 8,
  parameter logic [3:0] IDLE_LINES = 4'b1010
) (
  input  logic [REG_W-1:0] mcr_val,
  output mdm_lines_t       lines
);
  mdm_lines_t loop_lines;

  always_comb begin
    loop_lines.cts = mcr_val[MCR_RTS];
    loop_lines.dsr = mcr_val[MCR_DTR];
    loop_lines.ri  = mcr_val[MCR_OUT1];
    loop_lines.dcd = mcr_val[MCR_OUT2];
  end

  assign lines = mcr_val[MCR_LOOP] ? loop_lines : mdm_lines_t'(IDLE_LINES);
endmodule

// File: rtl/mdm_delta_track.sv
module mdm_delta_track
  import mdm_pkg::*;
#(
  parameter logic [3:0] IDLE_LINES = 4'b1010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic       rd_en,
  input  mdm_lines_t new_lines,
  output logic [7:0] msr_q,
  output logic       pend_q
);
  mdm_lines_t old_lines;
  mdm_delta_t old_delta;
  mdm_delta_t seen;
  mdm_delta_t delta_nx;
  mdm_lines_t lines_nx;

  assign old_lines = mdm_lines_t'(msr_q[7:4]);
  assign old_delta = mdm_delta_t'(msr_q[3:0]);

  always_comb begin
    seen.dcts = old_lines.cts ^ new_lines.cts;
    seen.ddsr = old_lines.dsr ^ new_lines.dsr;
    seen.ddcd = old_lines.dcd ^ new_lines.dcd;
    seen.teri = old_lines.ri & ~new_lines.ri;

    delta_nx = rd_en ? mdm_delta_t'(4'b0000) : old_delta;
    lines_nx = old_lines;
    if (wr_en) begin
      delta_nx = delta_nx | seen;
      lines_nx = new_lines;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      msr_q  <= {IDLE_LINES, 4'b0000};
      pend_q <= 1'b0;
    end else begin
      msr_q  <= {lines_nx, delta_nx};
      pend_q <= |delta_nx;
    end
  end
endmodule

// File: rtl/mdm_ctrl_status.sv
module mdm_ctrl_status
  import mdm_pkg::*;
#(
  parameter int         REG_W      = 8,
  parameter logic [3:0] IDLE_LINES = 4'b1010
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mcr_wr,
  input  logic [REG_W-1:0] mcr_wdata,
  input  logic             msr_rd,
  output logic [REG_W-1:0] mcr_q,
  output logic [7:0]       msr_q,
  output logic             delta_pend
);
  logic [REG_W-1:0] mcr_next;
  mdm_lines_t       next_lines;

  mdm_ctrl_reg #(.REG_W(REG_W), .KEEP_W(MCR_KEEP)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (mcr_wr),
    .wr_data    (mcr_wdata),
    .mcr_masked (mcr_next),
    .mcr_q      (mcr_q)
  );

  mdm_line_map #(.REG_W(REG_W), .IDLE_LINES(IDLE_LINES)) u_map (
    .mcr_val (mcr_next),
    .lines   (next_lines)
  );

  mdm_delta_track #(.IDLE_LINES(IDLE_LINES)) u_track (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (mcr_wr),
    .rd_en     (msr_rd),
    .new_lines (next_lines),
    .msr_q     (msr_q),
    .pend_q    (delta_pend)
  );
endmodule

// File: rtl/mdm_ctrl_status_chk.sv
module mdm_ctrl_status_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             mcr_wr,
  input logic             msr_rd,
  input logic [REG_W-1:0] mcr_q,
  input logic [7:0]       msr_q,
  input logic             delta_pend
);
  AST_MCR_HIGH_ZERO: assert property (@(posedge clk) disable iff (rst)
    mcr_q[REG_W-1:5] == '0); // R2

  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (rst)
    mcr_q[4] |-> (msr_q[4] == mcr_q[1] && msr_q[5] == mcr_q[0] &&
                  msr_q[6] == mcr_q[2] && msr_q[7] == mcr_q[3])); // R3

  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    !mcr_q[4] |-> msr_q[7:4] == 4'b1010); // R4

  AST_DELTA_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mcr_wr && !msr_rd) |=> ((msr_q[3:0] & $past(msr_q[3:0])) == $past(msr_q[3:0]))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!mcr_wr && !msr_rd) |=> $stable(msr_q)); // R7

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (msr_rd && !mcr_wr) |=> (msr_q[3:0] == 4'b0000 && msr_q[7:4] == $past(msr_q[7:4]))); // R8

  AST_PEND_MATCH: assert property (@(posedge clk) disable iff (rst)
    delta_pend == (msr_q[3:0] != 4'b0000)); // R9
endmodule

bind mdm_ctrl_status mdm_ctrl_status_chk #(.REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mcr_wr     (mcr_wr),
  .msr_rd     (msr_rd),
  .mcr_q      (mcr_q),
  .msr_q      (msr_q),
  .delta_pend (delta_pend)
);

// File: tb/mdm_ctrl_status_bench.sv
module mdm_ctrl_status_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mcr_wr = 1'b0;
  logic [7:0] mcr_wdata = 8'h00;
  logic       msr_rd = 1'b0;
  logic [7:0] mcr_q;
  logic [7:0] msr_q;
  logic       delta_pend;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] mcr;
    logic [7:0] msr;
    logic       pend;
    string      tag;
  } exp_t;

  exp_t sb[$];

  logic [7:0] mcr_m = 8'h00;
  logic [7:0] msr_m = 8'hA0;

  always #2.5 clk = ~clk;

  mdm_ctrl_status u_mdm_ctrl_status (
    .clk        (clk),
    .rst        (rst),
    .mcr_wr     (mcr_wr),
    .mcr_wdata  (mcr_wdata),
    .msr_rd     (msr_rd),
    .mcr_q      (mcr_q),
    .msr_q      (msr_q),
    .delta_pend (delta_pend)
  );

  // Status lines {DCD, RI, DSR, CTS} from a control value, per R3 and R4.
  function automatic logic [3:0] lines_of(input logic [7:0] m);
    return m[4] ? {m[3], m[2], m[0], m[1]} : 4'b1010;
  endfunction

  task automatic step(input logic r, input logic w, input logic [7:0] d,
                      input logic rd, input string tag);
    exp_t e;
    logic [3:0] nl, ol, nd;
    @(negedge clk);
    rst = r; mcr_wr = w; mcr_wdata = d; msr_rd = rd;
    if (r) begin
      mcr_m = 8'h00;
      msr_m = 8'hA0;
    end else begin
      nd = rd ? 4'b0000 : msr_m[3:0];
      ol = msr_m[7:4];
      if (w) begin
        mcr_m = d & 8'h1F;
        nl = lines_of(mcr_m);
        nd = nd | {ol[3] ^ nl[3], ol[2] & ~nl[2], ol[1] ^ nl[1], ol[0] ^ nl[0]};
        msr_m = {nl, nd};
      end else begin
        msr_m = {ol, nd};
      end
    end
    e.mcr = mcr_m; e.msr = msr_m; e.pend = (msr_m[3:0] != 0); e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      #1;
      check8(mcr_q, e.mcr, "mcr_q", e.tag);
      check8(msr_q, e.msr, "msr_q", e.tag);
      check8({7'b0, delta_pend}, {7'b0, e.pend}, "delta_pend", e.tag);
    end
  end

  initial begin
    step(1'b1, 1'b0, 8'h00, 1'b0, "R1 reset");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R1 idle after reset");
    step(1'b0, 1'b1, 8'hE3, 1'b0, "R2 R4 R11 high bits dropped, idle lines");
    step(1'b0, 1'b1, 8'h10, 1'b0, "R3 R5 enter loopback all low");
    step(1'b0, 1'b1, 8'h1F, 1'b0, "R3 R7 all lines high, deltas sticky");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8 read clears deltas");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R7 R9 hold with no strobe");
    step(1'b0, 1'b1, 8'h1B, 1'b0, "R6 RI falls");
    step(1'b0, 1'b1, 8'h1F, 1'b0, "R6 RI rises sets nothing new");
    step(1'b0, 1'b1, 8'h13, 1'b1, "R10 read and write same cycle");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8 read");
    step(1'b0, 1'b1, 8'h00, 1'b0, "R4 R5 leave loopback");
    step(1'b0, 1'b1, 8'h0F, 1'b0, "R11 R4 outputs without loopback");
    step(1'b1, 1'b0, 8'h00, 1'b0, "R1 reset mid run");
    step(1'b0, 1'b1, 8'h11, 1'b0, "R3 DTR drives DSR");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8 read");
    step(1'b0, 1'b1, 8'h12, 1'b0, "R3 RTS drives CTS");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8 read");
    step(1'b0, 1'b1, 8'h14, 1'b0, "R3 OUT1 drives RI");
    step(1'b0, 1'b0, 8'h00, 1'b1, "R8 read");
    step(1'b0, 1'b1, 8'h18, 1'b0, "R3 R6 OUT2 drives DCD, RI falls");
    step(1'b0, 1'b1, 8'h18, 1'b0, "R11 same value rewritten");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R9 idle");
    step(1'b0, 1'b0, 8'h00, 1'b0, "R7 idle");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, actual hung expected done");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule